// File: doc/BRIEF.md
# Interlocked Increment Pipeline with One Shared Adder

This block is a short pipeline of registered stages. A value enters at the front and leaves at the back. Several of the stages add one to the value as it passes. These adding stages are spaced a fixed number of stages apart, starting at a chosen stage, and they all use one common incrementer. Each stage register carries a valid bit next to its data. The valid bit selects which adding stage drives the common incrementer in a given cycle.

Only the first adding stage admits new work, so it is the only place where two users of the incrementer can collide. In any cycle where a later adding stage holds work that needs the incrementer, the block refuses the incoming value. It signals this as a stall towards the producer and places an empty slot at the first adding stage. Stages after that point always advance. Results therefore leave in order, and none are lost or repeated. A producer that does not space its inputs out gets the highest rate the sharing permits, without any input rule to follow.

With the default parameters the block has five stages of 8-bit data. The adding stages are 0, 2 and 4, so there are three additions spaced two stages apart, and every accepted value leaves as value plus 3. The parameters must place the last adding stage inside the pipeline: FIRST + PERIOD*(NOPS-1) < NSTG, with NOPS of at least 2.

Top module: `ilp_shared_add_pipe`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` is 0, `in_ready` is 1 and `stall` is 0, because every stage valid bit is cleared.
- R2: Every accepted input value v leaves on `out_data` as (v + NOPS) mod 2^W, where NOPS is the number of adding stages (3 by default).
- R3: A value accepted in cycle c appears with `out_valid` high in cycle c + NSTG (5 by default). In every other cycle `out_valid` stays low unless another accepted value is due then.
- R4: `in_ready` is low in cycle c exactly when some value was accepted in cycle c - i*PERIOD, for i in 1..NOPS-1. Those are the cycles in which a later adding stage is using the incrementer.
- R5: `stall` equals `in_valid` AND NOT `in_ready`. A stalled cycle accepts nothing, and the first adding stage holds an empty slot in the following cycle.
- R6: At most one of the later adding stages needs the incrementer in any cycle.
- R7: Results leave in the order they were accepted, and the number of results equals the number of accepted inputs after the pipeline drains.
- R8: With `in_valid` held high from an empty pipeline, acceptances repeat as PERIOD accepted cycles followed by (NOPS-1)*PERIOD refused cycles. This is one accepted input per NOPS cycles on average (20 in 60 cycles by default).
- R9: An input stream already spaced as PERIOD valid cycles followed by (NOPS-1)*PERIOD idle cycles is never stalled.
- R10: Additions wrap modulo 2^W. For example, 8'hFE leaves as 8'h01 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers `in_data` this cycle |
| in_data | input | W | Value to enter the pipeline |
| in_ready | output | 1 | Block accepts a value this cycle |
| stall | output | 1 | Offered value is refused because the incrementer is busy |
| out_valid | output | 1 | `out_data` holds a finished result |
| out_data | output | W | Result leaving the last stage |

## Verification
The hardest situation to reach is an overlap: several values in flight at once, each at a different adding stage, while the producer keeps offering new ones. Only then do refusals, empty slots and the rule that later stages keep moving all act together. The stimulus reaches this overlap with back-to-back valid inputs, with a pre-spaced stream that must never stall, and with random valid densities where refused values stay on the inputs. In every cycle the bench predicts readiness from its own history of accepted cycles and the spacing formula, and it matches each output against a queue of due cycles and expected sums.

// File: rtl/ilp_pkg.sv
package ilp_pkg;

  // Role of each pipeline stage
  localparam int KIND_PASS  = 0;  // plain register, always advances
  localparam int KIND_HOLD  = 1;  // upstream of first adder, frozen on stall
  localparam int KIND_FIRST = 2;  // first adding stage, admits or bubbles
  localparam int KIND_LATER = 3;  // later adding stage, always advances

  // Stage index of adding operation idx
  function automatic int op_stage(input int first, input int period, input int idx);
    return first + period * idx;
  endfunction

  function automatic int stage_kind(input int j, input int first, input int period,
                                    input int nops);
    if (j < first) return KIND_HOLD;
    if (j == first) return KIND_FIRST;
    if (((j - first) % period) == 0 && ((j - first) / period) < nops) return KIND_LATER;
    return KIND_PASS;
  endfunction

  // Total amount added by the pipeline to one value
  function automatic int total_increment(input int nops);
    return nops;
  endfunction

endpackage

// File: rtl/ilp_interlock.sv
module ilp_interlock #(
  parameter int NOPS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            first_req,
  input  logic [NOPS-2:0] later_req,
  output logic            busy,
  output logic            stall,
  output logic            admit
);

  // The incrementer is taken by whichever later stage holds valid work
  assign busy  = |later_req;
  assign stall = first_req & busy;
  assign admit = first_req & ~busy;

  // R6: even spacing keeps later users of the incrementer mutually exclusive
  p_one_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(later_req));

endmodule

// File: rtl/ilp_operand_mux.sv
module ilp_operand_mux #(
  parameter int W    = 8,
  parameter int NOPS = 3
) (
  input  logic [W-1:0]            first_opd,
  input  logic [NOPS-2:0][W-1:0]  later_opd,
  input  logic [NOPS-2:0]         later_req,
  output logic [W-1:0]            sum
);

  logic [W-1:0] sel;

  // Chain: each later stage with valid work overrides the earlier choice
  always_comb begin
    sel = first_opd;
    for (int i = 0; i < NOPS - 1; i++) begin
      if (later_req[i]) sel = later_opd[i];
    end
  end

  assign sum = sel + {{(W-1){1'b0}}, 1'b1};

endmodule

// File: rtl/ilp_stage.sv
module ilp_stage #(
  parameter int W    = 8,
  parameter int KIND = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] prev_data,
  input  logic         prev_en,
  input  logic [W-1:0] sum,
  input  logic         hold,
  input  logic         admit,
  output logic [W-1:0] q_data,
  output logic         q_en
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_en   <= 1'b0;
      q_data <= '0;
    end else if (KIND == ilp_pkg::KIND_HOLD) begin
      if (!hold) begin
        q_en   <= prev_en;
        q_data <= prev_data;
      end
    end else if (KIND == ilp_pkg::KIND_FIRST) begin
      q_en   <= admit;
      q_data <= sum;
    end else if (KIND == ilp_pkg::KIND_LATER) begin
      q_en   <= prev_en;
      q_data <= sum;
    end else begin
      q_en   <= prev_en;
      q_data <= prev_data;
    end
  end

endmodule

// File: rtl/ilp_shared_add_pipe.sv
module ilp_shared_add_pipe #(
  parameter int W      = 8,
  parameter int NSTG   = 5,
  parameter int FIRST  = 0,
  parameter int PERIOD = 2,
  parameter int NOPS   = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         stall,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  localparam int LAST_OP = ilp_pkg::op_stage(FIRST, PERIOD, NOPS - 1);

  logic [W-1:0]           q_d    [NSTG];
  logic [NSTG-1:0]        q_e;
  logic [W-1:0]           prev_d [NSTG];
  logic [NSTG-1:0]        prev_e;
  logic [NOPS-2:0]        later_req;
  logic [NOPS-2:0][W-1:0] later_opd;
  logic [W-1:0]           sum;
  logic                   busy;
  logic                   admit;

  // Inputs seen by each stage
  for (genvar j = 0; j < NSTG; j++) begin : g_prev
    if (j == 0) begin : g_head
      assign prev_d[j] = in_data;
      assign prev_e[j] = in_valid;
    end else begin : g_body
      assign prev_d[j] = q_d[j-1];
      assign prev_e[j] = q_e[j-1];
    end
  end

  // Requests of the later adding stages
  for (genvar i = 1; i < NOPS; i++) begin : g_req
    localparam int S = ilp_pkg::op_stage(FIRST, PERIOD, i);
    assign later_req[i-1] = prev_e[S];
    assign later_opd[i-1] = prev_d[S];
  end

  ilp_interlock #(.NOPS(NOPS)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_req (prev_e[FIRST]),
    .later_req (later_req),
    .busy      (busy),
    .stall     (stall),
    .admit     (admit)
  );

  ilp_operand_mux #(.W(W), .NOPS(NOPS)) u_mux (
    .first_opd (prev_d[FIRST]),
    .later_opd (later_opd),
    .later_req (later_req),
    .sum       (sum)
  );

  for (genvar j = 0; j < NSTG; j++) begin : g_stage
    ilp_stage #(.W(W), .KIND(ilp_pkg::stage_kind(j, FIRST, PERIOD, NOPS))) u_stg (
      .clk       (clk),
      .rst_n     (rst_n),
      .prev_data (prev_d[j]),
      .prev_en   (prev_e[j]),
      .sum       (sum),
      .hold      (stall),
      .admit     (admit),
      .q_data    (q_d[j]),
      .q_en      (q_e[j])
    );
  end

  if (FIRST == 0) begin : g_rdy_direct
    assign in_ready = ~busy;
  end else begin : g_rdy_held
    assign in_ready = ~stall;
  end

  assign out_valid = q_e[NSTG-1];
  assign out_data  = q_d[NSTG-1];

  // R1: reset clears the output valid
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R5: a refused cycle leaves an empty slot at the first adding stage
  p_stall_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !q_e[FIRST]);

  // R3: the last stage only fills from its neighbour
  if (LAST_OP < NSTG - 1 || FIRST < NSTG - 1) begin : g_lat_chk
    p_out_from_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_e[NSTG-1] |-> $past(q_e[NSTG-2]));
  end

  // R4: the first stage fills only after a handshake at the input
  if (FIRST == 0) begin : g_adm_chk
    p_admit_handshake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q_e[0] |-> $past(in_valid && in_ready));
  end

endmodule

// File: tb/test_ilp_shared_add_pipe.sv
`timescale 1ns/1ps
module test_ilp_shared_add_pipe;

  localparam int W    = 8;
  localparam int NSTG = 5;
  localparam int PER  = 2;
  localparam int NOPS = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, stall, out_valid;
  logic [W-1:0] out_data;

  always #4 clk = ~clk;

  ilp_shared_add_pipe i_ilp_shared_add_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .stall(stall), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_acc = 0;
  int n_out = 0;
  bit acc_hist [256];
  int due_q [$];
  logic [W-1:0] val_q [$];
  bit last_acc = 1'b0;
  logic [W-1:0] nxt = 8'h10;
  bit spaced_stall_seen;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit model_ready(input int c);
    for (int i = 1; i < NOPS; i++) begin
      if (c - i * PER >= 0 && acc_hist[(c - i * PER) % 256]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic step(input bit want_valid);
    bit er;
    bit acc;
    @(negedge clk);
    er = model_ready(cyc);
    check(in_ready === er, "R4 ready", int'(in_ready), int'(er));
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      check(out_valid === 1'b1, "R3 due output", int'(out_valid), 1);
      check(out_data === val_q[0], "R2 R10 R7 result", int'(out_data), int'(val_q[0]));
      void'(due_q.pop_front());
      void'(val_q.pop_front());
      n_out++;
    end else begin
      check(out_valid === 1'b0, "R3 R7 no output", int'(out_valid), 0);
    end
    if (!(in_valid && !last_acc)) begin
      in_valid = want_valid;
      in_data  = nxt;
    end
    #1;
    check(stall === (in_valid & ~er), "R5 stall", int'(stall), int'(in_valid & ~er));
    acc = in_valid & er;
    acc_hist[cyc % 256] = acc;
    if (acc) begin
      due_q.push_back(cyc + NSTG);
      val_q.push_back(in_data + W'(NOPS));
      n_acc++;
      nxt = nxt * 8'd5 + 8'd3;
    end
    last_acc = acc;
    cyc++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: during reset
    check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(stall === 1'b0, "R1 stall after reset", int'(stall), 0);

    // R8: back-to-back offers from an empty pipeline
    base = n_acc;
    for (int k = 0; k < 60; k++) step(1'b1);
    check(n_acc - base == 60 / (NOPS * PER) * PER, "R8 accept rate", n_acc - base,
          60 / (NOPS * PER) * PER);
    for (int k = 0; k < 20; k++) step(1'b0);

    // R9: pre-spaced stream is never refused
    spaced_stall_seen = 1'b0;
    for (int r = 0; r < 10; r++) begin
      for (int k = 0; k < PER; k++) begin
        step(1'b1);
        if (stall) spaced_stall_seen = 1'b1;
      end
      for (int k = 0; k < (NOPS - 1) * PER; k++) step(1'b0);
    end
    check(!spaced_stall_seen, "R9 spaced stream stalled", int'(spaced_stall_seen), 0);
    for (int k = 0; k < 10; k++) step(1'b0);

    // R10: values near the top of the range wrap
    nxt = 8'hFE;
    for (int k = 0; k < 12; k++) step(1'b1);
    for (int k = 0; k < 10; k++) step(1'b0);

    // Random densities with refused offers held on the inputs
    for (int d = 1; d <= 3; d++) begin
      for (int k = 0; k < 300; k++) step(($urandom % 4) < d);
    end
    for (int k = 0; k < 30; k++) step(1'b0);

    // R7: everything accepted has left
    check(due_q.size() == 0, "R7 drained", due_q.size(), 0);
    check(n_acc == n_out, "R7 count", n_out, n_acc);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule